// File: doc/BRIEF.md
# Table-Seeded Rotation Direction Predictor

This block is the front end of a shortened CORDIC sine/cosine engine working in rotation mode. It takes an unsigned angle between zero and pi/4 and returns two things in one registered bundle. The first is a coarse cosine/sine pair that stands in for the first five micro-rotations. The second is the full vector of direction bits for every remaining micro-rotation, which a separate shift-and-add stage then applies to the seed. The x/y micro-rotation arithmetic and the gain correction belong to that downstream stage and are not part of this block.

The high bits of the angle pick one of 64 bins. Each bin has a table entry with the cosine and sine of the bin centre and an adjustment term. A single adder combines the angle, a fixed stage constant and the adjustment term. Each bit of that sum is the direction of one later iteration. Because the later iterations use small angles, arctan(2^-i) is close enough to 2^-i that every direction is known at once. The block therefore carries no residual-angle register and never tests the sign of an iterated angle. Lookup, addition and output registers make up a single pipeline stage, and the block accepts a new angle on every clock.

Top module: `cordic_seed_predictor`

## Requirements
- R1: `ang_in` is an unsigned angle of value a/65536 radians. Only 0 <= a <= 51471 (pi/4) is in contract. The bin index is k = a[15:10], and bin k is centred on (2k+1)/128 radians.
- R2: `seed_x` is a signed two's-complement value with 19 fractional bits, equal to round(cos((2k+1)/128) * 2^19) within one LSB.
- R3: `seed_y` uses the same format and equals round(sin((2k+1)/128) * 2^19) within one LSB. For every in-contract angle, both seeds are strictly positive.
- R4: `rot_dir` has 12 bits. Bit j gives the direction of iteration i = 5 + j, where 1 means a +1 rotation and 0 means a -1 rotation. With s = a + 4095 - (1024k + 512), `rot_dir[j]` equals bit (12 - j) of s.
- R5: The signed sum over i = 5..16 of sigma_i * 2^(16-i), with sigma_i = 2*rot_dir[i-5] - 1, equals the in-bin residual (a mod 1024) - 512 or one less than it.
- R6: `seed_valid` is high exactly one clock after a cycle in which `ang_valid` was high, and low one clock after a cycle in which it was low.
- R7: A cycle with `ang_valid` low does not change `seed_x`, `seed_y` or `rot_dir`, whatever value `ang_in` holds.
- R8: A synchronous active-high `rst` clears `seed_valid`, `seed_x`, `seed_y` and `rot_dir` to zero at the next clock, even if `ang_valid` is high.
- R9: Angles presented on consecutive cycles each produce their own correct bundle on the following consecutive cycles.
- R10: At bin edges the result follows the bin of the angle. Angle 1023 uses bin 0 and angle 1024 uses bin 1. The angles 0 and 51471 both give results under R2 to R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ang_valid | input | 1 | Qualifies `ang_in` for this cycle |
| ang_in | input | 16 | Unsigned angle, 16 fractional bits, radians |
| seed_valid | output | 1 | Bundle below holds the result of the previous valid angle |
| seed_x | output | 21 | Coarse cosine seed, signed, 19 fractional bits |
| seed_y | output | 21 | Coarse sine seed, signed, 19 fractional bits |
| rot_dir | output | 12 | Direction bits, bit j for iteration 5 + j, 1 means positive |

## Verification
On every cycle the assertions check the one-clock valid latency, the holding of the bundle across idle cycles, the positivity of both seeds for in-contract angles, and the fact that the signed direction sum reconstructs the in-bin residual to within one LSB. The actual seed values against the true cosine and sine, the exact bit pattern of the direction vector, the reset clearing with a valid input present, and the switch at bin edges can only be shown by the bench's scenarios, which compute the expected values independently from the requirements.

// File: rtl/csd_pkg.sv
package csd_pkg;

  // Number of series terms used when the seed table is built at elaboration.
  localparam int TAYLOR_TERMS = 10;

  // pi/4 expressed with 30 fractional bits (truncated).
  localparam longint QUARTER_PI_Q30 = 64'sd843314856;

  // Largest in-contract angle code for an angle word of ang_w fraction bits.
  function automatic longint max_angle_code(input int ang_w);
    return QUARTER_PI_Q30 >>> (30 - ang_w);
  endfunction

  // Cosine or sine of th (30 fractional bits) through a truncated power series.
  function automatic longint trig_q30(input longint th, input bit want_sin);
    longint acc;
    longint term;
    longint th2;
    longint den;
    th2 = (th * th) >>> 30;
    if (want_sin) term = th;
    else          term = 64'sd1 <<< 30;
    acc = term;
    for (int n = 1; n <= TAYLOR_TERMS; n++) begin
      if (want_sin) den = longint'((2 * n) * (2 * n + 1));
      else          den = longint'((2 * n - 1) * (2 * n));
      term = -((term * th2) >>> 30) / den;
      acc  = acc + term;
    end
    return acc;
  endfunction

  // Seed value of bin k, rounded to frac fractional bits.
  function automatic longint seed_value(input int k, input bit want_sin,
                                        input int ang_w, input int idx_w,
                                        input int frac);
    longint centre;
    longint th;
    longint v;
    centre = longint'(2 * k + 1) <<< (ang_w - idx_w - 1);
    th     = centre <<< (30 - ang_w);
    v      = trig_q30(th, want_sin);
    return (v + (64'sd1 <<< (29 - frac))) >>> (30 - frac);
  endfunction

  // Adjustment term of bin k: minus the bin centre, in angle LSBs.
  function automatic longint adjust_value(input int k, input int ang_w, input int idx_w);
    longint bin;
    bin = 64'sd1 <<< (ang_w - idx_w);
    return -(longint'(k) * bin + (bin >>> 1));
  endfunction

  // Stage constant: sum of 2^(ang_w - i) over the predicted iterations.
  function automatic longint stage_constant(input int ang_w, input int it_lo, input int it_hi);
    longint c;
    c = 0;
    for (int i = it_lo; i <= it_hi; i++) c = c + (64'sd1 <<< (ang_w - i));
    return c;
  endfunction

endpackage

// File: rtl/csd_table.sv
module csd_table
  import csd_pkg::*;
#(
  parameter int ANG_W   = 16,
  parameter int IDX_W   = 6,
  parameter int XY_W    = 21,
  parameter int XY_FRAC = 19,
  localparam int DEPTH  = 1 << IDX_W,
  localparam int SUM_W  = ANG_W + 2
) (
  input  logic        [IDX_W-1:0] idx,
  output logic signed [XY_W-1:0]  cos_seed,
  output logic signed [XY_W-1:0]  sin_seed,
  output logic signed [SUM_W-1:0] adj
);

  logic signed [XY_W-1:0]  rom_cos [DEPTH];
  logic signed [XY_W-1:0]  rom_sin [DEPTH];
  logic signed [SUM_W-1:0] rom_adj [DEPTH];

  // Each entry is computed at elaboration from its bin index.
  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    localparam longint CV = seed_value(k, 1'b0, ANG_W, IDX_W, XY_FRAC);
    localparam longint SV = seed_value(k, 1'b1, ANG_W, IDX_W, XY_FRAC);
    localparam longint AV = adjust_value(k, ANG_W, IDX_W);
    assign rom_cos[k] = CV[XY_W-1:0];
    assign rom_sin[k] = SV[XY_W-1:0];
    assign rom_adj[k] = AV[SUM_W-1:0];
  end

  assign cos_seed = rom_cos[idx];
  assign sin_seed = rom_sin[idx];
  assign adj      = rom_adj[idx];

endmodule

// File: rtl/csd_predict.sv
module csd_predict
  import csd_pkg::*;
#(
  parameter int ANG_W   = 16,
  parameter int ITER_LO = 5,
  parameter int ITER_HI = 16,
  localparam int SUM_W  = ANG_W + 2,
  localparam int NDIR   = ITER_HI - ITER_LO + 1,
  localparam int TOP_B  = ANG_W + 1 - ITER_LO
) (
  input  logic        [ANG_W-1:0] angle,
  input  logic signed [SUM_W-1:0] adj,
  output logic        [NDIR-1:0]  dir
);

  localparam longint CST_V = stage_constant(ANG_W, ITER_LO, ITER_HI);
  localparam logic signed [SUM_W-1:0] CST = CST_V[SUM_W-1:0];

  logic signed [SUM_W-1:0] pred_sum;
  logic                    sum_unused;

  // One addition gives all directions: bit (TOP_B - j) drives iteration ITER_LO + j.
  assign pred_sum = $signed({2'b00, angle}) + CST + adj;

  for (genvar j = 0; j < NDIR; j++) begin : g_dir
    assign dir[j] = pred_sum[TOP_B-j];
  end

  assign sum_unused = ^{pred_sum[SUM_W-1:TOP_B+1], pred_sum[TOP_B-NDIR:0]};

endmodule

// File: rtl/csd_outreg.sv
module csd_outreg #(
  parameter int XY_W = 21,
  parameter int NDIR = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic signed [XY_W-1:0] x_d,
  input  logic signed [XY_W-1:0] y_d,
  input  logic        [NDIR-1:0] dir_d,
  output logic                   vld_q,
  output logic signed [XY_W-1:0] x_q,
  output logic signed [XY_W-1:0] y_q,
  output logic        [NDIR-1:0] dir_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      x_q   <= '0;
      y_q   <= '0;
      dir_q <= '0;
    end else begin
      vld_q <= load;
      if (load) begin
        x_q   <= x_d;
        y_q   <= y_d;
        dir_q <= dir_d;
      end
    end
  end

endmodule

// File: rtl/cordic_seed_predictor.sv
module cordic_seed_predictor
  import csd_pkg::*;
#(
  parameter int ANG_W   = 16,
  parameter int IDX_W   = 6,
  parameter int XY_W    = 21,
  parameter int XY_FRAC = 19,
  parameter int ITER_LO = 5,
  parameter int ITER_HI = 16,
  localparam int NDIR   = ITER_HI - ITER_LO + 1,
  localparam int SUM_W  = ANG_W + 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ang_valid,
  input  logic [ANG_W-1:0]       ang_in,
  output logic                   seed_valid,
  output logic signed [XY_W-1:0] seed_x,
  output logic signed [XY_W-1:0] seed_y,
  output logic [NDIR-1:0]        rot_dir
);

  logic signed [XY_W-1:0]  lut_x;
  logic signed [XY_W-1:0]  lut_y;
  logic signed [SUM_W-1:0] lut_adj;
  logic [NDIR-1:0]         pred_dir;

  csd_table #(
    .ANG_W(ANG_W), .IDX_W(IDX_W), .XY_W(XY_W), .XY_FRAC(XY_FRAC)
  ) u_table (
    .idx      (ang_in[ANG_W-1 -: IDX_W]),
    .cos_seed (lut_x),
    .sin_seed (lut_y),
    .adj      (lut_adj)
  );

  csd_predict #(
    .ANG_W(ANG_W), .ITER_LO(ITER_LO), .ITER_HI(ITER_HI)
  ) u_predict (
    .angle (ang_in),
    .adj   (lut_adj),
    .dir   (pred_dir)
  );

  csd_outreg #(
    .XY_W(XY_W), .NDIR(NDIR)
  ) u_outreg (
    .clk   (clk),
    .rst   (rst),
    .load  (ang_valid),
    .x_d   (lut_x),
    .y_d   (lut_y),
    .dir_d (pred_dir),
    .vld_q (seed_valid),
    .x_q   (seed_x),
    .y_q   (seed_y),
    .dir_q (rot_dir)
  );

endmodule

// File: rtl/csd_checker.sv
module csd_checker
  import csd_pkg::*;
#(
  parameter int ANG_W   = 16,
  parameter int IDX_W   = 6,
  parameter int XY_W    = 21,
  parameter int ITER_LO = 5,
  parameter int ITER_HI = 16,
  localparam int NDIR   = ITER_HI - ITER_LO + 1,
  localparam int BIN    = 1 << (ANG_W - IDX_W)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   ang_valid,
  input logic [ANG_W-1:0]       ang_in,
  input logic                   seed_valid,
  input logic signed [XY_W-1:0] seed_x,
  input logic signed [XY_W-1:0] seed_y,
  input logic [NDIR-1:0]        rot_dir
);

  localparam longint MAX_V = max_angle_code(ANG_W);
  localparam logic [ANG_W-1:0] MAX_ANG = MAX_V[ANG_W-1:0];

  logic in_contract;
  int   resid_q;
  int   recon;

  assign in_contract = ang_valid && (ang_in <= MAX_ANG);

  // Residual of the last accepted angle inside its bin, measured from the centre.
  always_ff @(posedge clk) begin
    if (rst) resid_q <= 0;
    else if (ang_valid) resid_q <= int'(ang_in % ANG_W'(BIN)) - BIN / 2;
  end

  always_comb begin
    recon = 0;
    for (int j = 0; j < NDIR; j++) begin
      if (rot_dir[j]) recon = recon + (1 <<< (ANG_W - ITER_LO - j));
      else            recon = recon - (1 <<< (ANG_W - ITER_LO - j));
    end
  end

  p_valid_rise_r6: assert property (@(posedge clk) disable iff (rst)
    ang_valid |=> seed_valid);

  p_valid_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !ang_valid |=> !seed_valid);

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !ang_valid |=> ($stable(seed_x) && $stable(seed_y) && $stable(rot_dir)));

  p_seed_pos_r3: assert property (@(posedge clk) disable iff (rst)
    in_contract |=> (seed_x > 0 && seed_y > 0));

  p_resid_r5: assert property (@(posedge clk) disable iff (rst)
    in_contract |=> ((recon - resid_q == 0) || (recon - resid_q == -1)));

endmodule

bind cordic_seed_predictor csd_checker #(
  .ANG_W(ANG_W), .IDX_W(IDX_W), .XY_W(XY_W), .ITER_LO(ITER_LO), .ITER_HI(ITER_HI)
) u_csd_checker (
  .clk        (clk),
  .rst        (rst),
  .ang_valid  (ang_valid),
  .ang_in     (ang_in),
  .seed_valid (seed_valid),
  .seed_x     (seed_x),
  .seed_y     (seed_y),
  .rot_dir    (rot_dir)
);

// File: tb/test_cordic_seed_predictor.sv
module test_cordic_seed_predictor;

  logic               clk = 1'b0;
  logic               rst;
  logic               ang_valid;
  logic [15:0]        ang_in;
  logic               seed_valid;
  logic signed [20:0] seed_x;
  logic signed [20:0] seed_y;
  logic [11:0]        rot_dir;

  int n_checks = 0;
  int n_fail   = 0;

  localparam int NVEC = 12;
  localparam logic [15:0] VEC [NVEC] = '{
    16'd0, 16'd1, 16'd511, 16'd512, 16'd513, 16'd1023,
    16'd1024, 16'd12345, 16'd25735, 16'd40000, 16'd51200, 16'd51471
  };

  always #5 clk = ~clk;

  cordic_seed_predictor i_cordic_seed_predictor (
    .clk(clk), .rst(rst), .ang_valid(ang_valid), .ang_in(ang_in),
    .seed_valid(seed_valid), .seed_x(seed_x), .seed_y(seed_y), .rot_dir(rot_dir)
  );

  function automatic int exp_seed(input logic [15:0] a, input bit want_sin);
    real th;
    int  k;
    k  = int'(a >> 10);
    th = real'(2 * k + 1) / 128.0;
    if (want_sin) return int'($floor($sin(th) * 524288.0 + 0.5));
    return int'($floor($cos(th) * 524288.0 + 0.5));
  endfunction

  function automatic logic [11:0] exp_dir(input logic [15:0] a);
    int          s;
    logic [11:0] d;
    s = int'(a & 16'd1023) + 3583;
    for (int j = 0; j < 12; j++) d[j] = s[12-j];
    return d;
  endfunction

  function automatic int recon_sum(input logic [11:0] d);
    int r;
    r = 0;
    for (int j = 0; j < 12; j++) r = d[j] ? r + (1 << (11 - j)) : r - (1 << (11 - j));
    return r;
  endfunction

  task automatic check_int(input string tag, input int act, input int exp, input int tol);
    n_checks++;
    if (act - exp > tol || exp - act > tol) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_bundle(input logic [15:0] a, input string ctx);
    int r;
    check_int({"R6 valid ", ctx}, int'(seed_valid), 1, 0);
    check_int({"R2 seed_x ", ctx}, int'(seed_x), exp_seed(a, 1'b0), 1);
    check_int({"R3 seed_y ", ctx}, int'(seed_y), exp_seed(a, 1'b1), 1);
    check_int({"R4 rot_dir ", ctx}, int'(rot_dir), int'(exp_dir(a)), 0);
    r = int'(a & 16'd1023) - 512;
    n_checks++;
    if (!(recon_sum(rot_dir) == r || recon_sum(rot_dir) == r - 1)) begin
      n_fail++;
      $display("FAIL R5 residual %s actual=%0d expected=%0d or %0d", ctx, recon_sum(rot_dir), r, r - 1);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_run();
  end

  initial begin
    rst = 1'b1; ang_valid = 1'b0; ang_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // Table walk: one angle, one result a clock later (R1, R2, R3, R4, R5, R10).
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      ang_valid = 1'b1; ang_in = VEC[v];
      @(negedge clk);
      ang_valid = 1'b0;
      check_bundle(VEC[v], $sformatf("vec %0d R1 R10", VEC[v]));
    end

    // R10 bin edge: 1023 and 1024 lie in different bins.
    @(negedge clk); ang_valid = 1'b1; ang_in = 16'd1023;
    @(negedge clk); ang_valid = 1'b0;
    check_int("R10 bin0 seed_y", int'(seed_y), exp_seed(16'd1023, 1'b1), 1);
    @(negedge clk); ang_valid = 1'b1; ang_in = 16'd1024;
    @(negedge clk); ang_valid = 1'b0;
    check_int("R10 bin1 seed_y", int'(seed_y), exp_seed(16'd1024, 1'b1), 1);

    // R7: idle cycles with a changing angle leave the bundle alone.
    @(negedge clk); ang_valid = 1'b1; ang_in = 16'd30000;
    @(negedge clk); ang_valid = 1'b0; ang_in = 16'd5000;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); ang_in = ang_in + 16'd7000;
    end
    check_int("R7 hold valid low", int'(seed_valid), 0, 0);
    check_int("R7 hold seed_x", int'(seed_x), exp_seed(16'd30000, 1'b0), 1);
    check_int("R7 hold rot_dir", int'(rot_dir), int'(exp_dir(16'd30000)), 0);

    // R9: back-to-back angles on consecutive cycles.
    @(negedge clk); ang_valid = 1'b1; ang_in = VEC[0];
    for (int v = 1; v < NVEC; v++) begin
      @(negedge clk);
      check_bundle(VEC[v-1], $sformatf("R9 stream %0d", VEC[v-1]));
      ang_in = VEC[v];
    end
    @(negedge clk);
    ang_valid = 1'b0;
    check_bundle(VEC[NVEC-1], "R9 stream last");

    // R8: reset with a valid angle present clears the bundle.
    ang_valid = 1'b1; ang_in = 16'd20000; rst = 1'b1;
    @(negedge clk);
    check_int("R8 reset valid", int'(seed_valid), 0, 0);
    check_int("R8 reset seed_x", int'(seed_x), 0, 0);
    check_int("R8 reset seed_y", int'(seed_y), 0, 0);
    check_int("R8 reset rot_dir", int'(rot_dir), 0, 0);
    rst = 1'b0; ang_valid = 1'b0;
    @(negedge clk);
    check_int("R6 idle after reset", int'(seed_valid), 0, 0);

    finish_run();
  end

endmodule